// File: doc/BRIEF.md
# Three-Bit Pixel Bus Decoder

The block sits at the receiving end of a narrow video symbol link that carries one 3-bit code per color clock, twice the CPU bus rate. Each code either names a pixel colour or carries a control event. Sync, blank and the high-resolution mode flag all travel on the same three wires as pixel data. The decoder turns each code into a colour register index, strobes that mark which half of the pixel slot is valid, and the horizontal blank and vertical sync flags. It also keeps a latched high-resolution flag.

A pixel code is read in one of three ways, depending on the mode. In normal mode it is one whole pixel. When the high-resolution flag is set, it is two fine pixels, and a half-clock phase input selects which one is emitted. When the split mode input is asserted, consecutive pixel codes supply the left half of a pixel and then the right half. Colour lookup, sprite overlay, collision logic and analog output belong to the stages that follow.

Top module: `pxb_decoder`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls, every output is 0. This includes `hires_o`.
- R2: Code 000 gives `color_o`=0 (background) with both `left_vld_o` and `right_vld_o` high, and `hblank_o`/`vsync_o` low.
- R3: Code 001 gives `vsync_o`=1, both strobes low, `hblank_o` low and `color_o`=0.
- R4: Code 010 gives `hblank_o`=1 and clears the high-resolution flag. Code 011 gives `hblank_o`=1 and sets it. Both strobes stay low and `color_o` is 0.
- R5: The high-resolution flag changes only on codes 010 and 011, and it holds through all other codes. `hires_o` shows the new value one cycle after the blank code.
- R6: In normal mode (split mode off, flag clear), code 1ab gives `color_o` = ab+1 (playfield 0..3 as 1..4) with both strobes high.
- R7: With split mode off and the flag set, code 1ab is two fine pixels. When `hr_phase_i`=0, only `left_vld_o` is high and the pixel bit is a. When `hr_phase_i`=1, only `right_vld_o` is high and the pixel bit is b. A bit of 1 gives `color_o`=2 (playfield 1) and a bit of 0 gives `color_o`=3 (playfield 2).
- R8: With split mode on, which takes precedence over the flag, pixel codes alternate. The first gives `left_vld_o` only and the next gives `right_vld_o` only, each with `color_o` = ab+1. Any non-pixel code, or a cycle with split mode off, restarts the order at the left half.
- R9: Every output is registered. The response to the code sampled at one clock edge appears after that edge and holds for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Color clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 3 | Incoming symbol |
| split_en_i | input | 1 | Half-pixel split mode enable |
| hr_phase_i | input | 1 | Fine-pixel phase in high-resolution mode |
| color_o | output | 3 | Colour register index: 0 background, 1..4 playfield 0..3 |
| left_vld_o | output | 1 | Left half of pixel slot valid |
| right_vld_o | output | 1 | Right half of pixel slot valid |
| hblank_o | output | 1 | Horizontal blank |
| vsync_o | output | 1 | Vertical sync |
| hires_o | output | 1 | Latched high-resolution flag |

## Verification
Some properties are checked by the assertions on every cycle. Sync and blank must never coincide with a pixel strobe. The high-resolution flag may move only after a blank code. A right-only half in split mode must follow directly after a left-only half. In high-resolution mode the colour is limited to the two fine-pixel registers. Other behaviour only the bench scenarios can show. These are the exact colour index for each code under each combination of flag, split mode and phase, and the restart of the half order after a control code. Also bench-only are the one-cycle timing of the flag and of the outputs, and the reset values.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  localparam int CODE_W = 3;
  localparam int COL_W  = 3;
  localparam int PF_W   = 2;

  typedef enum logic [2:0] {
    K_BAK    = 3'd0,
    K_VSYNC  = 3'd1,
    K_HBL_LO = 3'd2,
    K_HBL_HI = 3'd3,
    K_PF     = 3'd4
  } kind_e;

  localparam logic [COL_W-1:0] COL_BAK = 3'd0;
  localparam logic [COL_W-1:0] COL_FG  = 3'd2;  // playfield 1 for a set fine pixel
  localparam logic [COL_W-1:0] COL_BG  = 3'd3;  // playfield 2 for a clear fine pixel
endpackage

// File: rtl/pxb_classify.sv
module pxb_classify
  import pxb_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output kind_e             kind_o,
  output logic [PF_W-1:0]   pf_o
);
  always_comb begin
    pf_o = code_i[PF_W-1:0];
    if (code_i[CODE_W-1]) begin
      kind_o = K_PF;
    end else begin
      unique case (code_i[1:0])
        2'b00:   kind_o = K_BAK;
        2'b01:   kind_o = K_VSYNC;
        2'b10:   kind_o = K_HBL_LO;
        default: kind_o = K_HBL_HI;
      endcase
    end
  end
endmodule

// File: rtl/pxb_mode_track.sv
module pxb_mode_track
  import pxb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  kind_e kind_i,
  input  logic  split_en_i,
  output logic  hires_q,
  output logic  half_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hires_q <= 1'b0;
    end else if (kind_i == K_HBL_LO) begin
      hires_q <= 1'b0;
    end else if (kind_i == K_HBL_HI) begin
      hires_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= 1'b0;
    end else if (split_en_i && kind_i == K_PF) begin
      half_q <= ~half_q;
    end else begin
      half_q <= 1'b0;
    end
  end

  AST_HIRES_ONLY_ON_BLANK: assert property (@(posedge clk) disable iff (rst)
    !$stable(hires_q) |-> ($past(kind_i) == K_HBL_LO || $past(kind_i) == K_HBL_HI)); // R5
endmodule

// File: rtl/pxb_out_stage.sv
module pxb_out_stage
  import pxb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  kind_e             kind_i,
  input  logic [PF_W-1:0]   pf_i,
  input  logic              split_en_i,
  input  logic              hr_phase_i,
  input  logic              hires_q,
  input  logic              half_q,
  output logic [COL_W-1:0]  color_o,
  output logic              left_vld_o,
  output logic              right_vld_o,
  output logic              hblank_o,
  output logic              vsync_o
);
  logic [COL_W-1:0] col_d;
  logic             lv_d, rv_d, hb_d, vs_d, fine_bit;

  assign fine_bit = hr_phase_i ? pf_i[0] : pf_i[1];

  always_comb begin
    col_d = COL_BAK;
    lv_d  = 1'b0;
    rv_d  = 1'b0;
    hb_d  = 1'b0;
    vs_d  = 1'b0;
    unique case (kind_i)
      K_BAK: begin
        lv_d = 1'b1;
        rv_d = 1'b1;
      end
      K_VSYNC:  vs_d = 1'b1;
      K_HBL_LO,
      K_HBL_HI: hb_d = 1'b1;
      default: begin
        if (split_en_i) begin
          col_d = COL_W'(pf_i) + COL_W'(1);
          lv_d  = ~half_q;
          rv_d  = half_q;
        end else if (hires_q) begin
          col_d = fine_bit ? COL_FG : COL_BG;
          lv_d  = ~hr_phase_i;
          rv_d  = hr_phase_i;
        end else begin
          col_d = COL_W'(pf_i) + COL_W'(1);
          lv_d  = 1'b1;
          rv_d  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      color_o     <= COL_BAK;
      left_vld_o  <= 1'b0;
      right_vld_o <= 1'b0;
      hblank_o    <= 1'b0;
      vsync_o     <= 1'b0;
    end else begin
      color_o     <= col_d;
      left_vld_o  <= lv_d;
      right_vld_o <= rv_d;
      hblank_o    <= hb_d;
      vsync_o     <= vs_d;
    end
  end

  AST_SYNC_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (vsync_o || hblank_o) |-> (!left_vld_o && !right_vld_o && color_o == COL_BAK)); // R3
  AST_BLANK_SYNC_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(vsync_o && hblank_o)); // R4
  AST_SPLIT_ORDER: assert property (@(posedge clk) disable iff (rst)
    (right_vld_o && !left_vld_o && $past(split_en_i)) |-> $past(left_vld_o && !right_vld_o)); // R8
endmodule

// File: rtl/pxb_decoder.sv
module pxb_decoder
  import pxb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  input  logic              split_en_i,
  input  logic              hr_phase_i,
  output logic [COL_W-1:0]  color_o,
  output logic              left_vld_o,
  output logic              right_vld_o,
  output logic              hblank_o,
  output logic              vsync_o,
  output logic              hires_o
);
  kind_e           kind;
  logic [PF_W-1:0] pf;
  logic            hires_q, half_q;

  pxb_classify u_cls (.code_i(code_i), .kind_o(kind), .pf_o(pf));

  pxb_mode_track u_mode (
    .clk(clk), .rst(rst), .kind_i(kind), .split_en_i(split_en_i),
    .hires_q(hires_q), .half_q(half_q)
  );

  pxb_out_stage u_out (
    .clk(clk), .rst(rst), .kind_i(kind), .pf_i(pf),
    .split_en_i(split_en_i), .hr_phase_i(hr_phase_i),
    .hires_q(hires_q), .half_q(half_q),
    .color_o(color_o), .left_vld_o(left_vld_o), .right_vld_o(right_vld_o),
    .hblank_o(hblank_o), .vsync_o(vsync_o)
  );

  assign hires_o = hires_q;

  AST_HIRES_COLOURS: assert property (@(posedge clk) disable iff (rst)
    ($past(hires_q) && !$past(split_en_i) && (left_vld_o ^ right_vld_o))
      |-> (color_o == COL_FG || color_o == COL_BG)); // R7
endmodule

// File: tb/tb_pxb_decoder.sv
module tb_pxb_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] code = 3'd0;
  logic       split = 1'b0, ph = 1'b0;
  logic [2:0] color;
  logic       lv, rv, hb, vs, hr;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_hires = 0, m_half = 0;
  int e_col = 0, e_lv = 0, e_rv = 0, e_hb = 0, e_vs = 0, e_hr = 0;
  string e_tag = "R1";
  bit have_exp = 1'b0;

  always #2.5 clk = ~clk;

  pxb_decoder dut (
    .clk(clk), .rst(rst), .code_i(code), .split_en_i(split), .hr_phase_i(ph),
    .color_o(color), .left_vld_o(lv), .right_vld_o(rv),
    .hblank_o(hb), .vsync_o(vs), .hires_o(hr)
  );

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // R9: the expectation made for the inputs driven before an edge is compared after that edge
  task automatic step(int c, int s, int p);
    @(negedge clk);
    if (have_exp) begin
      cmp(e_tag, {color, lv, rv, hb, vs}, (e_col << 4) | (e_lv << 3) | (e_rv << 2) | (e_hb << 1) | e_vs);
      cmp("R5", hr, e_hr);
    end
    code = c[2:0]; split = s[0]; ph = p[0];
    e_col = 0; e_lv = 0; e_rv = 0; e_hb = 0; e_vs = 0;
    if (c == 0) begin
      e_lv = 1; e_rv = 1; e_tag = "R2";
    end else if (c == 1) begin
      e_vs = 1; e_tag = "R3";
    end else if (c < 4) begin
      e_hb = 1; e_tag = "R4";
      m_hires = (c == 3);
    end else if (s != 0) begin
      e_col = (c % 4) + 1; e_tag = "R8";
      if (m_half == 0) e_lv = 1; else e_rv = 1;
    end else if (m_hires != 0) begin
      int b;
      b = p ? (c % 2) : ((c / 2) % 2);
      e_col = b ? 2 : 3; e_tag = "R7";
      e_lv = !p; e_rv = p;
    end else begin
      e_col = (c % 4) + 1; e_tag = "R6";
      e_lv = 1; e_rv = 1;
    end
    m_half = (s != 0 && c >= 4) ? !m_half : 0;
    e_hr = m_hires;
    have_exp = 1'b1;
  endtask

  initial begin
    #150000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int lfsr;
    code = 3'd3;
    repeat (4) @(negedge clk);
    cmp("R1", {color, lv, rv, hb, vs, hr}, 0);
    @(negedge clk);
    rst = 1'b0;
    cmp("R1", {color, lv, rv, hb, vs, hr}, 0);
    code = 3'd0;
    // every code under every flag / split / phase combination
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 2; p++)
          for (int c = 0; c < 8; c++) begin
            step(f ? 3 : 2, s, p);
            step(c, s, p);
          end
    // R8: long split runs, interrupted by control codes and by split off
    step(3, 1, 0);
    for (int i = 0; i < 5; i++) step(4 + i % 4, 1, i % 2);
    step(0, 1, 0);
    for (int i = 0; i < 3; i++) step(7 - i, 1, 0);
    step(5, 0, 0);
    for (int i = 0; i < 3; i++) step(4 + i, 1, 1);
    step(1, 1, 0);
    step(6, 1, 0);
    // R5: flag persists through pixel and sync codes
    step(3, 0, 0);
    for (int i = 0; i < 6; i++) step(i % 2 ? 1 : 5, 0, i % 2);
    step(2, 0, 0);
    for (int i = 0; i < 4; i++) step(6, 0, i % 2);
    // pseudo-random stream
    lfsr = 32'h1ACE;
    for (int i = 0; i < 3000; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      step(lfsr % 8, (lfsr >> 4) % 2 & (lfsr >> 7) % 2, (lfsr >> 5) % 2);
    end
    step(0, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule